// File: doc/BRIEF.md
# I2C Start-Condition Reservation Controller

This block sits beside an I2C master serializer and decides what happens when software asks for a start condition. If the bus is idle, it orders a start at once. If another master holds the bus, it records the request as a reservation. It then issues the start by itself on the first stop condition seen on the bus, so the request is neither lost nor turned into a collision.

Bus occupancy comes from simple start-detect and stop-detect strobes. Arbitration loss and the software release bit arrive as single-cycle strobes. Every accepted request also starts a wait timer. The length of that wait comes from a 3-bit speed/clock select. When the wait has elapsed, software reads the master-status flag to learn whether it obtained the bus or is still holding a reservation. Once this node owns the bus, a write strobe to the shift register launches the address byte.

Each input is a synchronous single-cycle strobe. The asynchronous active-low reset is released through a two-stage synchronizer, so internal logic leaves reset two clock edges after `rst_n` rises.

Top module: `i2c_start_reserve`

## Requirements
- R1: During reset, and until the first input strobe after reset, every output is 0.
- R2: `busy_o` becomes 1 one cycle after `start_det_i` and 0 one cycle after `stop_det_i`. If both strobes come in the same cycle, the stop wins.
- R3: A request (`start_req_i`) with no reservation pending, made while the bus is free (`busy_o`=0 or `stop_det_i`=1 in that cycle), gives a one-cycle `start_gen_o` pulse in the next cycle, with `master_o`=1 from that cycle on.
- R4: A request with no reservation pending, made while the bus is busy and no stop is seen, sets `pending_o` in the next cycle and gives no `start_gen_o` pulse.
- R5: While `pending_o`=1, a `stop_det_i` with neither `req_clear_i` nor `release_i` gives a `start_gen_o` pulse in the next cycle. In that same cycle it clears `pending_o` and sets `master_o`.
- R6: While `pending_o`=1, `req_clear_i` or `release_i` clears `pending_o` in the next cycle with no start. This cancellation takes priority over a stop in the same cycle. With no reservation pending, `req_clear_i` has no effect.
- R7: A request made while `pending_o`=1 is ignored. It neither restarts the wait timer nor changes `pending_o`.
- R8: An accepted request clears `wait_done_o`, sets `wait_active_o` in the next cycle, and raises `wait_done_o` exactly W clock edges after the request edge, with `wait_active_o` falling at the same edge. W = WAIT_SCALE times the base count for `wait_sel_i`: 000→26, 001→46, 010→92, 011→37, 100→16, 101→32, 110→13, 111→92 (reserved). An accepted request made while the timer runs reloads it.
- R9: `master_o` is cleared in the next cycle by `stop_det_i`, `arb_lost_i` or `release_i`, unless a start is issued at that same edge, in which case it is set.
- R10: `addr_launch_o` gives a one-cycle pulse in the cycle after `shift_wr_i` if `master_o` was 1 when the strobe came; otherwise the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req_i | input | 1 | Software start request strobe |
| req_clear_i | input | 1 | Software withdraws the start request |
| release_i | input | 1 | Software bus-release strobe |
| start_det_i | input | 1 | Start condition detected on the bus |
| stop_det_i | input | 1 | Stop condition detected on the bus |
| arb_lost_i | input | 1 | Arbitration lost strobe |
| shift_wr_i | input | 1 | Shift-register write strobe |
| wait_sel_i | input | 3 | Wait-length select (speed bit, two clock bits) |
| start_gen_o | output | 1 | One-cycle order to the serializer to drive a start |
| busy_o | output | 1 | Bus is occupied |
| pending_o | output | 1 | Reservation is held |
| master_o | output | 1 | This node is bus master |
| wait_active_o | output | 1 | Wait timer running |
| wait_done_o | output | 1 | Wait elapsed since the last accepted request |
| addr_launch_o | output | 1 | One-cycle order to send the address byte |

## Verification
The bench builds the block with WAIT_SCALE=1. At that value the longest wait is 92 cycles, so every one of the eight select codes, including the reserved one, is timed to the exact edge within a short run. The small count also lets the randomized phase put requests, cancellations and stops on top of running timers and live reservations, which reaches the reload and same-cycle priority cases. A behavioural model built from counters and flags is compared with every output on every clock.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned WAIT_MAX = 92;

  // base wait length per select code; code 7 is reserved and takes the longest
  function automatic int unsigned wait_base(input logic [SEL_W-1:0] sel);
    int unsigned r;
    case (sel)
      3'd0:    r = 26;
      3'd1:    r = 46;
      3'd2:    r = 92;
      3'd3:    r = 37;
      3'd4:    r = 16;
      3'd5:    r = 32;
      3'd6:    r = 13;
      default: r = WAIT_MAX;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sr_rst_sync.sv
module sr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sr_bus_track.sv
module sr_bus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det_i,
  input  logic stop_det_i,
  output logic busy_o
);

  logic busy_d, busy_q;

  always_comb begin
    busy_d = busy_q;
    if (stop_det_i)       busy_d = 1'b0;
    else if (start_det_i) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  a_r2_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det_i |=> !busy_o);
  a_r2_start_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det_i && !stop_det_i) |=> busy_o);

endmodule

// File: rtl/sr_resv_ctrl.sv
module sr_resv_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req_i,
  input  logic req_clear_i,
  input  logic release_i,
  input  logic stop_det_i,
  input  logic arb_lost_i,
  input  logic shift_wr_i,
  input  logic busy_i,
  output logic accept_o,
  output logic start_gen_o,
  output logic pending_o,
  output logic master_o,
  output logic addr_launch_o
);

  logic pend_d, pend_q;
  logic gen_d, gen_q;
  logic mst_d, mst_q;
  logic launch_d, launch_q;
  logic bus_free, fire, cancel;

  always_comb begin
    bus_free = !busy_i || stop_det_i;
    accept_o = start_req_i && !pend_q;
    cancel   = pend_q && (req_clear_i || release_i);
    fire     = pend_q && stop_det_i && !cancel;

    gen_d = (accept_o && bus_free) || fire;

    pend_d = pend_q;
    if (accept_o && !bus_free) pend_d = 1'b1;
    else if (fire || cancel)   pend_d = 1'b0;

    mst_d = mst_q;
    if (gen_d)                                    mst_d = 1'b1;
    else if (stop_det_i || arb_lost_i || release_i) mst_d = 1'b0;

    launch_d = shift_wr_i && mst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      gen_q    <= 1'b0;
      mst_q    <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      gen_q    <= gen_d;
      mst_q    <= mst_d;
      launch_q <= launch_d;
    end
  end

  assign start_gen_o   = gen_q;
  assign pending_o     = pend_q;
  assign master_o      = mst_q;
  assign addr_launch_o = launch_q;

  a_r3_gen_implies_master: assert property (@(posedge clk) disable iff (!rst_n)
    start_gen_o |-> master_o);
  a_r4_reserve_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req_i && !pending_o && busy_i && !stop_det_i) |=> (pending_o && !start_gen_o));
  a_r5_fire_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && stop_det_i && !req_clear_i && !release_i) |=> (start_gen_o && master_o && !pending_o));
  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && (req_clear_i || release_i)) |=> (!pending_o && !start_gen_o));
  a_r9_master_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((arb_lost_i || release_i) && !start_req_i && !pending_o) |=> !master_o);
  a_r10_launch_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    addr_launch_o |-> $past(master_o && shift_wr_i));

endmodule

// File: rtl/sr_wait_timer.sv
module sr_wait_timer
  import i2c_sr_pkg::*;
#(
  parameter int unsigned WAIT_SCALE = 1,
  parameter int unsigned CNT_W      = $clog2(WAIT_MAX * WAIT_SCALE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             active_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_d, cnt_q, wait_len;
  logic             act_d, act_q, done_d, done_q;
  logic             cnt_en;

  always_comb begin
    wait_len = CNT_W'(wait_base(sel_i) * WAIT_SCALE);
    cnt_en   = load_i || act_q;
    cnt_d    = cnt_q;
    act_d    = act_q;
    done_d   = done_q;
    if (load_i) begin
      cnt_d  = wait_len;
      act_d  = 1'b1;
      done_d = 1'b0;
    end else if (act_q) begin
      if (cnt_q == CNT_W'(1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign active_o = act_q;
  assign done_o   = done_q;

  a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (cnt_q != '0));
  a_r8_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cnt_q == CNT_W'(1) && !load_i) |=> (done_o && !active_o));
  a_r8_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o && !done_o));

endmodule

// File: rtl/i2c_start_reserve.sv
module i2c_start_reserve
  import i2c_sr_pkg::*;
#(
  parameter int unsigned WAIT_SCALE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req_i,
  input  logic             req_clear_i,
  input  logic             release_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             arb_lost_i,
  input  logic             shift_wr_i,
  input  logic [SEL_W-1:0] wait_sel_i,
  output logic             start_gen_o,
  output logic             busy_o,
  output logic             pending_o,
  output logic             master_o,
  output logic             wait_active_o,
  output logic             wait_done_o,
  output logic             addr_launch_o
);

  localparam int unsigned CNT_W = $clog2(WAIT_MAX * WAIT_SCALE + 1);

  logic rst_n_int;
  logic accept;

  sr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sr_bus_track u_bus (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .busy_o      (busy_o)
  );

  sr_resv_ctrl u_resv (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .start_req_i   (start_req_i),
    .req_clear_i   (req_clear_i),
    .release_i     (release_i),
    .stop_det_i    (stop_det_i),
    .arb_lost_i    (arb_lost_i),
    .shift_wr_i    (shift_wr_i),
    .busy_i        (busy_o),
    .accept_o      (accept),
    .start_gen_o   (start_gen_o),
    .pending_o     (pending_o),
    .master_o      (master_o),
    .addr_launch_o (addr_launch_o)
  );

  sr_wait_timer #(.WAIT_SCALE(WAIT_SCALE), .CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_i   (accept),
    .sel_i    (wait_sel_i),
    .active_o (wait_active_o),
    .done_o   (wait_done_o)
  );

  a_r7_ignore_second: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pending_o && start_req_i && !req_clear_i && !release_i && !stop_det_i) |=> pending_o);
  a_r1_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_gen_o |=> !start_gen_o || $past(start_req_i || stop_det_i));

endmodule

// File: tb/i2c_start_reserve_tb.sv
module i2c_start_reserve_tb;

  localparam int unsigned WAIT_SCALE = 1;

  logic clk, rst_n;
  logic start_req, req_clear, rel, start_det, stop_det, arb_lost, shift_wr;
  logic [2:0] wsel;
  logic start_gen, busy, pending, master, wact, wdone, launch;

  int n_tests = 0;
  int n_fail  = 0;

  i2c_start_reserve #(.WAIT_SCALE(WAIT_SCALE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req_i(start_req), .req_clear_i(req_clear),
    .release_i(rel), .start_det_i(start_det), .stop_det_i(stop_det),
    .arb_lost_i(arb_lost), .shift_wr_i(shift_wr), .wait_sel_i(wsel),
    .start_gen_o(start_gen), .busy_o(busy), .pending_o(pending), .master_o(master),
    .wait_active_o(wact), .wait_done_o(wdone), .addr_launch_o(launch)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int wait_len(input logic [2:0] s);
    int b;
    case (s)
      3'd0: b = 26; 3'd1: b = 46; 3'd2: b = 92; 3'd3: b = 37;
      3'd4: b = 16; 3'd5: b = 32; 3'd6: b = 13; default: b = 92;
    endcase
    return b * WAIT_SCALE;
  endfunction

  // behavioural reference
  bit m_busy, m_pend, m_gen, m_mst, m_act, m_done, m_launch;
  int m_cnt;
  int m_sync;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_gen = 0; m_mst = 0; m_act = 0; m_done = 0;
      m_launch = 0; m_cnt = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      bit free, acc, fire, canc, ngen;
      free = !m_busy || stop_det;
      acc  = start_req && !m_pend;
      canc = m_pend && (req_clear || rel);
      fire = m_pend && stop_det && !canc;
      ngen = (acc && free) || fire;
      m_launch = shift_wr && m_mst;
      if (ngen) m_mst = 1;
      else if (stop_det || arb_lost || rel) m_mst = 0;
      if (acc && !free) m_pend = 1;
      else if (fire || canc) m_pend = 0;
      m_gen = ngen;
      if (stop_det) m_busy = 0;
      else if (start_det) m_busy = 1;
      if (acc) begin
        m_cnt = wait_len(wsel); m_act = 1; m_done = 0;
      end else if (m_act) begin
        if (m_cnt == 1) begin m_act = 0; m_done = 1; end
        m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every output against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "busy_o", busy, m_busy);
      chk("R4", "pending_o", pending, m_pend);
      chk("R3", "start_gen_o", start_gen, m_gen);
      chk("R9", "master_o", master, m_mst);
      chk("R8", "wait_active_o", wact, m_act);
      chk("R8", "wait_done_o", wdone, m_done);
      chk("R10", "addr_launch_o", launch, m_launch);
    end
  end

  task automatic idle();
    start_req = 0; req_clear = 0; rel = 0; start_det = 0; stop_det = 0;
    arb_lost = 0; shift_wr = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle();
    end
  endtask

  // drive one strobe pattern for a single cycle
  task automatic pulse(input bit rq, input bit cl, input bit rl, input bit sd,
                       input bit pd, input bit al, input bit sw);
    @(negedge clk);
    start_req = rq; req_clear = cl; rel = rl; start_det = sd;
    stop_det = pd; arb_lost = al; shift_wr = sw;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(); wsel = 3'd0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: outputs at zero while reset held
    chk("R1", "outputs in reset", {start_gen, busy, pending, master, wact, wdone, launch}, 0);
    rst_n = 1;
    cyc(4);
    chk("R1", "outputs after reset", {start_gen, busy, pending, master, wact, wdone, launch}, 0);

    // R3 + R8: immediate start on free bus, every select code timed
    for (int s = 0; s < 8; s++) begin
      wsel = 3'(s);
      pulse(1, 0, 0, 0, 0, 0, 0);
      // pulse returns one cycle after the request edge: start_gen visible now
      chk("R3", "immediate start pulse", start_gen, 1);
      pulse(0, 0, 0, 1, 0, 0, 1);     // serializer start seen + address write
      chk("R10", "address launch", launch, 1);
      cyc(wait_len(3'(s)));
      chk("R8", "wait done", wdone, 1);
      pulse(0, 0, 0, 0, 1, 0, 0);     // stop: release bus
      chk("R9", "master cleared by stop", master, 0);
    end

    // R4 + R5: reservation while another master holds the bus
    wsel = 3'd6;
    pulse(0, 0, 0, 1, 0, 0, 0);
    chk("R2", "busy after start_det", busy, 1);
    pulse(1, 0, 0, 0, 0, 0, 1);
    chk("R4", "reservation held", pending, 1);
    chk("R10", "no launch without master", launch, 0);
    pulse(1, 0, 0, 0, 0, 0, 0);       // R7: ignored second request
    chk("R7", "still pending", pending, 1);
    cyc(20);
    pulse(0, 0, 0, 0, 1, 0, 0);
    chk("R5", "auto start after stop", start_gen, 1);
    chk("R5", "master after auto start", master, 1);
    pulse(0, 0, 0, 1, 0, 1, 0);
    chk("R9", "master cleared by arb loss", master, 0);

    // R6: cancellation by clear, then by release racing a stop
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0, 0, 0);
    chk("R6", "clear cancels", pending, 0);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 0, 1, 0, 1, 0, 0);
    chk("R6", "release beats stop", start_gen, 0);
    chk("R6", "no reservation left", pending, 0);
    pulse(0, 1, 0, 0, 0, 0, 0);
    chk("R6", "clear without reservation", {pending, start_gen, master}, 0);

    // randomized phase: all strobes mixed, model compared each cycle
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      start_req = ($urandom_range(0, 7) == 0);
      req_clear = ($urandom_range(0, 29) == 0);
      rel       = ($urandom_range(0, 39) == 0);
      start_det = ($urandom_range(0, 9) == 0);
      stop_det  = ($urandom_range(0, 11) == 0);
      arb_lost  = ($urandom_range(0, 29) == 0);
      shift_wr  = ($urandom_range(0, 5) == 0);
      wsel      = 3'($urandom_range(0, 7));
    end
    cyc(100);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule